// File: doc/BRIEF.md
# Frame-Linear LCD Timing Generator

This block drives a parallel LCD panel. It produces horizontal sync, vertical sync, data-enable, a pixel request to the upstream pixel source, and the pixel word itself. The horizontal timing comes from a line counter that restarts at the leading edge of every hsync. The vertical timing does not use a line counter. A single frame counter advances once per pixel clock across the whole frame, and every vertical quantity is programmed as an absolute pixel-clock position inside the frame. Software works these positions out from the mode: the frame period is vtotal·htotal, the vsync length is (vsync_end−vsync_start)·htotal, the first displayed position is (vtotal−vsync_start)·htotal+skew, and the last displayed position is frame period−(vsync_start−vdisplay)·htotal+skew−1. Software also works out the horizontal window from the mode. It starts at htotal−hsync_start and ends at htotal−(hsync_start−hdisplay)−1, and both values are counted from the start of hsync.

The block holds the timing configuration in an active copy. That copy is loaded only when the block starts running and at each frame boundary, so any change to the timing inputs waits for a clean frame start. Clearing the enable does not stop the block at once. The current frame finishes first, and a later re-enable then loads the new configuration from a known point. When the pixel source has no data for a requested pixel, the block outputs a substitute colour in its place.

Top module: `lcd_frame_timing`

## Requirements
- R1: While rst_ni is low, hsync_o, vsync_o, de_o, pix_req_o and pix_o are all 0. After reset the block is idle.
- R2: While running, the line counter h steps through 0..h_period−1 once per clock and wraps to 0. hsync is active for every h < hs_width.
- R3: While running, the frame counter f steps through 0..f_period−1 once per clock. At the wrap both f and h return to 0. vsync is active when skew ≤ f < skew+vs_len.
- R4: de_o is high exactly when v_act_start ≤ f ≤ v_act_end and h_act_start ≤ h ≤ h_act_end, with both bounds included. While idle, de_o is 0.
- R5: pix_req_o is asserted in the clock before de_o, from the same counter state. hsync_o, vsync_o, de_o and pix_o are registered and lag that counter state by one clock.
- R6: hsync_o is the internal active level XOR hs_low_i, and vsync_o is the internal active level XOR vs_low_i. A value of 1 on a polarity input makes that sync active-low. The polarity inputs are not shadowed and take effect on the next clock. While idle, each sync output sits at its inactive level.
- R7: In a clock where pix_req_o is high and pix_valid_i is high, pix_i is registered to pix_o. Whenever de_o is low, pix_o is 0.
- R8: In a clock where pix_req_o is high and pix_valid_i is low (underflow), pix_o takes one of two substitutes. If uf_recover_i is 1, it takes the 8-bit fill_clr_i copied into every byte lane. If uf_recover_i is 0, it takes border_clr_i.
- R9: en_i sampled high while idle starts the block on the next clock with h = f = 0, and the timing inputs are captured into the active copy.
- R10: en_i sampled low while running has no effect until the last position of the frame (f = f_period−1). At that point the block goes idle. If en_i is high again at that position, the block runs on into the next frame without a gap.
- R11: A change to the timing inputs while running does not take effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| h_period_i | input | 12 | Line period in clocks |
| hs_width_i | input | 12 | Hsync pulse width in clocks |
| h_act_start_i | input | 12 | First displayed line position |
| h_act_end_i | input | 12 | Last displayed line position |
| hs_skew_i | input | 12 | Offset of the vertical events from the frame start |
| f_period_i | input | 24 | Frame period in clocks |
| vs_len_i | input | 24 | Vsync length in clocks |
| v_act_start_i | input | 24 | First displayed frame position |
| v_act_end_i | input | 24 | Last displayed frame position |
| hs_low_i | input | 1 | Hsync active-low select |
| vs_low_i | input | 1 | Vsync active-low select |
| border_clr_i | input | PIX_W | Substitute colour when recovery is off |
| uf_recover_i | input | 1 | Use the fill colour on underflow |
| fill_clr_i | input | 8 | Fill colour, copied into every byte lane |
| pix_i | input | PIX_W | Pixel from the source |
| pix_valid_i | input | 1 | Source has a pixel for the current request |
| pix_req_o | output | 1 | Pixel request, one clock ahead of de_o |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | PIX_W | Pixel to the panel |

## Verification
The assertions check four things on every clock. The request always leads data-enable by one cycle. The pixel word is zero outside the display window. An underflow always produces the substitute colour chosen by the recovery input. While idle, the syncs sit at their inactive levels, and the block starts or stops only in agreement with the enable input. Other behaviour can only be shown by the bench scenarios running against a cycle model: the window positions for a given configuration, the frame-linear vsync placement with skew, a configuration change that waits for the frame boundary, and a disable that finishes the frame or is cancelled before the frame ends.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  parameter int unsigned TG_HW = 12;
  parameter int unsigned TG_FW = 24;

  typedef logic [TG_HW-1:0] hpos_t;
  typedef logic [TG_FW-1:0] fpos_t;

  typedef struct packed {
    hpos_t h_period;
    hpos_t hs_width;
    hpos_t h_act_start;
    hpos_t h_act_end;
    hpos_t skew;
    fpos_t f_period;
    fpos_t vs_len;
    fpos_t v_act_start;
    fpos_t v_act_end;
  } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_tg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  tg_cfg_t cfg_i,
  input  logic    frame_last_i,
  output logic    run_o,
  output tg_cfg_t act_o
);
  // active copy only moves at start or frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      act_o <= '0;
    end else if (!run_o) begin
      if (en_i) begin
        run_o <= 1'b1;
        act_o <= cfg_i;
      end
    end else if (frame_last_i) begin
      if (en_i) act_o <= cfg_i;
      else      run_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_tg_counters.sv
module lcd_tg_counters
  import lcd_tg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  hpos_t h_period_i,
  input  fpos_t f_period_i,
  output hpos_t hcnt_o,
  output fpos_t fcnt_o,
  output logic  frame_last_o
);
  logic line_last;

  assign frame_last_o = run_i && (fcnt_o == f_period_i - fpos_t'(1));
  assign line_last    = hcnt_o >= h_period_i - hpos_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      fcnt_o <= '0;
    end else if (!run_i || frame_last_o) begin
      hcnt_o <= '0;
      fcnt_o <= '0;
    end else begin
      fcnt_o <= fcnt_o + fpos_t'(1);
      hcnt_o <= line_last ? '0 : hcnt_o + hpos_t'(1);
    end
  end
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out
  import lcd_tg_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  tg_cfg_t          act_i,
  input  hpos_t            hcnt_i,
  input  fpos_t            fcnt_i,
  input  logic             hs_low_i,
  input  logic             vs_low_i,
  input  logic [PIX_W-1:0] border_clr_i,
  input  logic             uf_recover_i,
  input  logic [7:0]       fill_clr_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             pix_req_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int unsigned LANES = PIX_W / 8;

  logic [PIX_W-1:0] fill_wide;
  logic [PIX_W-1:0] pix_sel;
  logic             hs_act, vs_act, h_in, v_in;
  fpos_t            skew_f;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign fill_wide[l*8 +: 8] = fill_clr_i;
  end

  assign skew_f = fpos_t'(act_i.skew);
  assign hs_act = run_i && (hcnt_i < act_i.hs_width);
  assign vs_act = run_i && (fcnt_i >= skew_f) && ((fcnt_i - skew_f) < act_i.vs_len);
  assign h_in   = (hcnt_i >= act_i.h_act_start) && (hcnt_i <= act_i.h_act_end);
  assign v_in   = (fcnt_i >= act_i.v_act_start) && (fcnt_i <= act_i.v_act_end);
  assign pix_req_o = run_i && h_in && v_in;

  always_comb begin
    if (pix_valid_i)       pix_sel = pix_i;
    else if (uf_recover_i) pix_sel = fill_wide;
    else                   pix_sel = border_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_o   <= '0;
    end else begin
      hsync_o <= hs_act ^ hs_low_i;
      vsync_o <= vs_act ^ vs_low_i;
      de_o    <= pix_req_o;
      pix_o   <= pix_req_o ? pix_sel : '0;
    end
  end
endmodule

// File: rtl/lcd_frame_timing.sv
module lcd_frame_timing
  import lcd_tg_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TG_HW-1:0] h_period_i,
  input  logic [TG_HW-1:0] hs_width_i,
  input  logic [TG_HW-1:0] h_act_start_i,
  input  logic [TG_HW-1:0] h_act_end_i,
  input  logic [TG_HW-1:0] hs_skew_i,
  input  logic [TG_FW-1:0] f_period_i,
  input  logic [TG_FW-1:0] vs_len_i,
  input  logic [TG_FW-1:0] v_act_start_i,
  input  logic [TG_FW-1:0] v_act_end_i,
  input  logic             hs_low_i,
  input  logic             vs_low_i,
  input  logic [PIX_W-1:0] border_clr_i,
  input  logic             uf_recover_i,
  input  logic [7:0]       fill_clr_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  output logic             pix_req_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] pix_o
);
  tg_cfg_t cfg, act;
  logic    run, frame_last;
  hpos_t   hcnt;
  fpos_t   fcnt;

  always_comb begin
    cfg.h_period    = h_period_i;
    cfg.hs_width    = hs_width_i;
    cfg.h_act_start = h_act_start_i;
    cfg.h_act_end   = h_act_end_i;
    cfg.skew        = hs_skew_i;
    cfg.f_period    = f_period_i;
    cfg.vs_len      = vs_len_i;
    cfg.v_act_start = v_act_start_i;
    cfg.v_act_end   = v_act_end_i;
  end

  lcd_tg_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cfg_i        (cfg),
    .frame_last_i (frame_last),
    .run_o        (run),
    .act_o        (act)
  );

  lcd_tg_counters u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .h_period_i   (act.h_period),
    .f_period_i   (act.f_period),
    .hcnt_o       (hcnt),
    .fcnt_o       (fcnt),
    .frame_last_o (frame_last)
  );

  lcd_tg_out #(.PIX_W(PIX_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .act_i        (act),
    .hcnt_i       (hcnt),
    .fcnt_i       (fcnt),
    .hs_low_i     (hs_low_i),
    .vs_low_i     (vs_low_i),
    .border_clr_i (border_clr_i),
    .uf_recover_i (uf_recover_i),
    .fill_clr_i   (fill_clr_i),
    .pix_i        (pix_i),
    .pix_valid_i  (pix_valid_i),
    .pix_req_o    (pix_req_o),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .de_o         (de_o),
    .pix_o        (pix_o)
  );
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             run_i,
  input logic             hs_low_i,
  input logic             vs_low_i,
  input logic             uf_recover_i,
  input logic             pix_valid_i,
  input logic [PIX_W-1:0] border_clr_i,
  input logic [7:0]       fill_clr_i,
  input logic             pix_req_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic [PIX_W-1:0] pix_o
);
  localparam int unsigned LANES = PIX_W / 8;

  a_r5_req_leads_de: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |=> de_o);

  a_r7_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> pix_o == '0);

  a_r8_underflow_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && !$past(pix_valid_i)) |->
      pix_o == ($past(uf_recover_i) ? {LANES{$past(fill_clr_i)}} : $past(border_clr_i)));

  a_r6_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (hsync_o == $past(hs_low_i)) && (vsync_o == $past(vs_low_i)) && !de_o);

  a_r9_start_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(en_i));

  a_r10_stop_needs_no_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> !$past(en_i));
endmodule

bind lcd_frame_timing lcd_tg_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .run_i        (run),
  .hs_low_i     (hs_low_i),
  .vs_low_i     (vs_low_i),
  .uf_recover_i (uf_recover_i),
  .pix_valid_i  (pix_valid_i),
  .border_clr_i (border_clr_i),
  .fill_clr_i   (fill_clr_i),
  .pix_req_o    (pix_req_o),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .de_o         (de_o),
  .pix_o        (pix_o)
);

// File: tb/lcd_frame_timing_tb.sv
module lcd_frame_timing_tb;
  localparam int PIX_W = 24;
  localparam int CYC   = 4;

  logic clk = 0, rst_n = 0, en = 0;
  logic [11:0] c_hp, c_hw, c_hs, c_he, c_sk;
  logic [23:0] c_fp, c_vl, c_vs, c_ve;
  logic hs_low = 0, vs_low = 0, uf_rec = 1, pv = 1;
  logic [PIX_W-1:0] border = '0, pix = '0;
  logic [7:0] fill = 8'hff;
  logic req, hs_o, vs_o, de_o;
  logic [PIX_W-1:0] pix_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  always #(CYC/2) clk = ~clk;

  lcd_frame_timing #(.PIX_W(PIX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .h_period_i(c_hp), .hs_width_i(c_hw), .h_act_start_i(c_hs), .h_act_end_i(c_he),
    .hs_skew_i(c_sk), .f_period_i(c_fp), .vs_len_i(c_vl), .v_act_start_i(c_vs),
    .v_act_end_i(c_ve), .hs_low_i(hs_low), .vs_low_i(vs_low), .border_clr_i(border),
    .uf_recover_i(uf_rec), .fill_clr_i(fill), .pix_i(pix), .pix_valid_i(pv),
    .pix_req_o(req), .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o), .pix_o(pix_o)
  );

  // reference model built from the requirements
  bit m_run;
  int m_h, m_f, a_hp, a_hw, a_hs, a_he, a_sk, a_fp, a_vl, a_vs, a_ve;
  bit e_hs, e_vs, e_de, e_uf;
  logic [PIX_W-1:0] e_pix;
  bit m_last;

  function automatic bit m_de();
    return m_run && m_f >= a_vs && m_f <= a_ve && m_h >= a_hs && m_h <= a_he;
  endfunction

  function automatic logic [PIX_W-1:0] exp_pix();
    if (pv) return pix;
    if (uf_rec) return {(PIX_W/8){fill}};
    return border;
  endfunction

  task automatic load_act();
    a_hp = c_hp; a_hw = c_hw; a_hs = c_hs; a_he = c_he; a_sk = c_sk;
    a_fp = c_fp; a_vl = c_vl; a_vs = c_vs; a_ve = c_ve;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_f = 0; e_hs = 0; e_vs = 0; e_de = 0; e_uf = 0; e_pix = '0;
      a_hp = 0; a_hw = 0; a_hs = 0; a_he = 0; a_sk = 0; a_fp = 0; a_vl = 0; a_vs = 0; a_ve = 0;
    end else begin
      e_hs  = (m_run && m_h < a_hw) ^ hs_low;
      e_vs  = (m_run && m_f >= a_sk && (m_f - a_sk) < a_vl) ^ vs_low;
      e_uf  = m_de() && !pv;
      e_pix = m_de() ? exp_pix() : '0;
      e_de  = m_de();
      m_last = m_run && (m_f == a_fp - 1);
      if (!m_run) begin
        if (en) begin m_run = 1; load_act(); end
      end else if (m_last) begin
        m_h = 0; m_f = 0;
        if (en) load_act(); else m_run = 0;
      end else begin
        m_f = m_f + 1;
        m_h = (m_h >= a_hp - 1) ? 0 : m_h + 1;
      end
    end
  end

  task automatic chk(string req_id, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s [scenario %s] actual=%0h expected=%0h t=%0t",
               req_id, what, tag, act, exp, $time);
    end
  endtask

  task automatic check_cycle();
    chk("R2", "hsync", hs_o, e_hs);
    chk("R3", "vsync", vs_o, e_vs);
    chk("R4", "de", de_o, e_de);
    chk("R5", "pix_req", req, m_de());
    chk(e_uf ? "R8" : "R7", "pix", pix_o, e_pix);
  endtask

  task automatic step(int n, int pct_valid);
    repeat (n) begin
      @(negedge clk);
      check_cycle();
      pix = PIX_W'($urandom);
      pv  = ($urandom_range(99) < pct_valid);
    end
  endtask

  task automatic set_mode(int ht, int hd, int hss, int hse, int vt, int vd, int vss, int vse, int sk);
    c_hp = 12'(ht);
    c_hw = 12'(hse - hss);
    c_hs = 12'(ht - hss);
    c_he = 12'(ht - (hss - hd) - 1);
    c_sk = 12'(sk);
    c_fp = 24'(vt * ht);
    c_vl = 24'((vse - vss) * ht);
    c_vs = 24'((vt - vss) * ht + sk);
    c_ve = 24'(vt * ht - (vss - vd) * ht + sk - 1);
  endtask

  task automatic rand_mode();
    int ht = $urandom_range(20, 10);
    int hd = $urandom_range(ht - 4, 4);
    int hss = $urandom_range(ht - 2, hd + 1);
    int hse = $urandom_range(ht - 1, hss + 1);
    int vt = $urandom_range(9, 5);
    int vd = $urandom_range(vt - 3, 2);
    int vss = $urandom_range(vt - 2, vd + 1);
    int vse = $urandom_range(vt - 1, vss + 1);
    set_mode(ht, hd, hss, hse, vt, vd, vss, vse, $urandom_range(ht - 1, 0));
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1cd0));
    set_mode(12, 6, 8, 10, 6, 3, 4, 5, 0);
    // R1: reset values
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset outputs", {hs_o, vs_o, de_o, req, |pix_o}, 5'b0);
    end
    rst_n = 1;
    tag = "R6"; // idle levels follow polarity inputs
    step(3, 100);
    hs_low = 1; vs_low = 1;
    step(3, 100);
    chk("R6", "idle hsync level", hs_o, 1);
    chk("R6", "idle vsync level", vs_o, 1);
    hs_low = 0; vs_low = 0;
    step(2, 100);
    // R9: start, directed mode
    tag = "R9"; en = 1;
    step(2, 100);
    chk("R9", "hsync active right after start", hs_o, 1);
    step(150, 100);
    // R8: underflow with both substitutes
    tag = "R8"; border = 24'h123456; fill = 8'h5a;
    step(80, 50);
    uf_rec = 0;
    step(80, 50);
    uf_rec = 1; fill = 8'hff; border = '0;
    // R11: mid-frame change waits for frame start
    tag = "R11";
    step(20, 90);
    set_mode(16, 8, 10, 13, 7, 4, 5, 6, 3);
    step(250, 90);
    // R6: live polarity while running
    tag = "R6"; hs_low = 1;
    step(60, 90);
    vs_low = 1;
    step(60, 90);
    hs_low = 0; vs_low = 0;
    // R10: disable finishes the frame, then idle
    tag = "R10"; en = 0;
    step(150, 90);
    chk("R10", "idle after frame end, de", de_o, 0);
    en = 1;
    step(40, 90);
    en = 0;
    step(10, 90);
    en = 1; // re-raise before frame end: no gap
    step(200, 90);
    // random modes, polarities, and occasional disable
    for (int i = 0; i < 10; i++) begin
      tag = "R2";
      rand_mode();
      hs_low = $urandom_range(1); vs_low = $urandom_range(1); uf_rec = $urandom_range(1);
      border = PIX_W'($urandom); fill = 8'($urandom);
      step(2 * int'(c_fp) + 30, 85);
      if (i % 3 == 2) begin
        tag = "R10"; en = 0;
        step(int'(c_fp) + 20, 85);
        en = 1;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule